// File: doc/BRIEF.md
# Fast-Acquisition Timeout Controller

This block steers a frequency synthesizer through its fast-acquisition phase. Each write of a new tuning word (a one-cycle `tune_load` pulse) starts a countdown measured in phase-comparison cycles, marked by the `cmp_tick` strobe. While the countdown runs, the block selects the fast-acquisition charge-pump gain code and an optional comparison-rate reduction factor. When the programmed number of comparison cycles has elapsed, both fall back to their steady-state values together, without any action from software.

A 14-bit timeout value selects the mode. Values of four and above enable timed fast acquisition, and the auxiliary output pin then drives the loop-filter switch. Values 0 to 3 turn the timer off and make the pin a simple general-purpose output. Code 3 in that range also holds the fast gain permanently. The pin is asserted in the same cycle as the gain switch and is released one comparison cycle before the gain reverts, so that the external filter resistor is removed while the high gain is still applied.

Top module: `fastlock_timeout_ctrl`

## Requirements
- R1: After reset, with timeout value 4 or more, `cp_gain` equals `gain_steady`, `rate_factor` is 1, and the pin is driven (`aux_pin_oe`=1) low.
- R2: With timeout value 0 the pin is not driven (`aux_pin_oe`=0). With value 1 it is driven low, and with value 2 it is driven high. In all three cases `cp_gain` equals `gain_steady`.
- R3: With timeout value 3, `cp_gain` equals `gain_fast` permanently, the pin is driven high and `rate_factor` is 1.
- R4: With timeout value T>=4, a `tune_load` pulse makes `cp_gain` equal `gain_fast` and drives the pin high from the next cycle on.
- R5: The fast state lasts exactly T cycles in which `cmp_tick` is high. Cycles without `cmp_tick` do not count. `cp_gain` returns to `gain_steady` in the cycle after the T-th tick.
- R6: The pin goes low in the cycle after the (T-1)-th tick, while `cp_gain` still equals `gain_fast`.
- R7: During the fast state `rate_factor` equals 2 to the power `csr_code` (1, 2, 4 or 8). At all other times it is 1.
- R8: A `tune_load` that arrives during the fast state reloads the count to the current timeout value. If a tick arrives in the same cycle, the load wins.
- R9: A `tune_load` while the timeout value is below 4 has no effect on `cp_gain`, `rate_factor` or the pin.
- R10: With timeout value 4 or more and no fast state in progress, the pin is driven low and `cp_gain` equals `gain_steady`.
- R11: If the timeout value drops below 4 during the fast state, the fast state is abandoned. A later change back to 4 or more does not resume it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tune_load | input | 1 | One-cycle pulse marking a new tuning write |
| cmp_tick | input | 1 | One-cycle strobe per phase-comparison cycle |
| timeout_val | input | 14 | Timeout in comparison cycles; values 0 to 3 select a general-purpose pin mode |
| gain_steady | input | 2 | Steady-state charge-pump gain code |
| gain_fast | input | 2 | Fast-acquisition charge-pump gain code |
| csr_code | input | 2 | Comparison-rate reduction code applied during the fast state |
| cp_gain | output | 2 | Active charge-pump gain code |
| rate_factor | output | 4 | Active comparison-rate reduction factor |
| aux_pin_oe | output | 1 | Drive enable of the auxiliary pin |
| aux_pin_val | output | 1 | Value of the auxiliary pin |

## Verification
The hardest situations to reach are the edges of the countdown. These are a reload or a timeout drop that lands exactly where a tick would end the fast state, a load and a tick in the same cycle, and the one-tick window in which the pin is already low but the gain is still fast. Directed sequences use small timeouts and sparse, gapped ticks to step into each of these windows. A randomised phase then mixes loads, ticks and mode changes with short timeouts, so that these coincidences occur many times. One directed run counts down the full 16383-cycle timeout to cover the top of the range.

// File: rtl/ftc_pkg.sv
package ftc_pkg;

    // General-purpose pin behaviour selected by low timeout values
    typedef enum logic [1:0] {
        GP_HIZ   = 2'd0,
        GP_LOW   = 2'd1,
        GP_HIGH  = 2'd2,
        GP_FORCE = 2'd3
    } gp_code_e;

    typedef struct packed {
        logic     timed_en;
        gp_code_e gp_code;
    } ftc_mode_t;

    typedef struct packed {
        logic oe;
        logic val;
    } pin_drive_t;

    function automatic pin_drive_t gp_pin(input gp_code_e code);
        pin_drive_t p;
        case (code)
            GP_HIZ:  p = '{oe: 1'b0, val: 1'b0};
            GP_LOW:  p = '{oe: 1'b1, val: 1'b0};
            default: p = '{oe: 1'b1, val: 1'b1};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/ftc_mode_dec.sv
module ftc_mode_dec
    import ftc_pkg::*;
#(
    parameter int TMO_W   = 14,
    parameter int MIN_TMO = 4
) (
    input  logic [TMO_W-1:0] timeout_val,
    output ftc_mode_t        mode
);
    localparam logic [TMO_W-1:0] MinT = TMO_W'(MIN_TMO);

    always_comb begin
        mode.timed_en = (timeout_val >= MinT);
        mode.gp_code  = gp_code_e'(timeout_val[1:0]);
    end
endmodule

// File: rtl/ftc_counter.sv
module ftc_counter #(
    parameter int TMO_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             timed_en,
    input  logic             load,
    input  logic             tick,
    input  logic [TMO_W-1:0] timeout_val,
    output logic [TMO_W-1:0] cnt_q,
    output logic             active,
    output logic             switch_on
);
    logic [TMO_W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (!timed_en)
            cnt_d = '0;
        else if (load)
            cnt_d = timeout_val;
        else if (tick && (cnt_q != '0))
            cnt_d = cnt_q - TMO_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign active    = (cnt_q != '0);
    assign switch_on = (cnt_q > TMO_W'(1));
endmodule

// File: rtl/ftc_out_mux.sv
module ftc_out_mux
    import ftc_pkg::*;
#(
    parameter int GAIN_W = 2,
    parameter int CSR_W  = 2,
    parameter int RATE_W = 4
) (
    input  ftc_mode_t         mode,
    input  logic              active,
    input  logic              switch_on,
    input  logic [GAIN_W-1:0] gain_steady,
    input  logic [GAIN_W-1:0] gain_fast,
    input  logic [CSR_W-1:0]  csr_code,
    output logic [GAIN_W-1:0] cp_gain,
    output logic [RATE_W-1:0] rate_factor,
    output pin_drive_t        pin
);
    logic fast_now;

    always_comb begin
        fast_now = mode.timed_en && active;
        if (mode.timed_en) begin
            cp_gain = fast_now ? gain_fast : gain_steady;
            pin     = '{oe: 1'b1, val: switch_on};
        end else begin
            cp_gain = (mode.gp_code == GP_FORCE) ? gain_fast : gain_steady;
            pin     = gp_pin(mode.gp_code);
        end
        rate_factor = fast_now ? (RATE_W'(1) << csr_code) : RATE_W'(1);
    end
endmodule

// File: rtl/fastlock_timeout_ctrl.sv
module fastlock_timeout_ctrl
    import ftc_pkg::*;
#(
    parameter int TMO_W   = 14,
    parameter int GAIN_W  = 2,
    parameter int CSR_W   = 2,
    parameter int MIN_TMO = 4,
    localparam int RATE_W = 2 ** CSR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tune_load,
    input  logic              cmp_tick,
    input  logic [TMO_W-1:0]  timeout_val,
    input  logic [GAIN_W-1:0] gain_steady,
    input  logic [GAIN_W-1:0] gain_fast,
    input  logic [CSR_W-1:0]  csr_code,
    output logic [GAIN_W-1:0] cp_gain,
    output logic [RATE_W-1:0] rate_factor,
    output logic              aux_pin_oe,
    output logic              aux_pin_val
);
    ftc_mode_t        mode;
    logic [TMO_W-1:0] cnt_q;
    logic             active;
    logic             switch_on;
    pin_drive_t       pin;

    ftc_mode_dec #(.TMO_W(TMO_W), .MIN_TMO(MIN_TMO)) u_dec (
        .timeout_val (timeout_val),
        .mode        (mode)
    );

    ftc_counter #(.TMO_W(TMO_W)) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .timed_en    (mode.timed_en),
        .load        (tune_load),
        .tick        (cmp_tick),
        .timeout_val (timeout_val),
        .cnt_q       (cnt_q),
        .active      (active),
        .switch_on   (switch_on)
    );

    ftc_out_mux #(.GAIN_W(GAIN_W), .CSR_W(CSR_W), .RATE_W(RATE_W)) u_mux (
        .mode        (mode),
        .active      (active),
        .switch_on   (switch_on),
        .gain_steady (gain_steady),
        .gain_fast   (gain_fast),
        .csr_code    (csr_code),
        .cp_gain     (cp_gain),
        .rate_factor (rate_factor),
        .pin         (pin)
    );

    assign aux_pin_oe  = pin.oe;
    assign aux_pin_val = pin.val;
endmodule

// File: rtl/ftc_checker.sv
module ftc_checker #(
    parameter int TMO_W   = 14,
    parameter int GAIN_W  = 2,
    parameter int RATE_W  = 4,
    parameter int MIN_TMO = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              tune_load,
    input logic              cmp_tick,
    input logic [TMO_W-1:0]  timeout_val,
    input logic [GAIN_W-1:0] gain_fast,
    input logic [GAIN_W-1:0] cp_gain,
    input logic [RATE_W-1:0] rate_factor,
    input logic              aux_pin_oe,
    input logic              aux_pin_val,
    input logic [TMO_W-1:0]  cnt_q
);
    localparam logic [TMO_W-1:0] MinT = TMO_W'(MIN_TMO);

    // R4: a load in timed mode captures the timeout value
    p_load_capture_r4: assert property (@(posedge clk) disable iff (rst)
        (tune_load && timeout_val >= MinT) |=> (cnt_q == $past(timeout_val)));

    // R5: the count only moves on a tick or a load
    p_hold_without_tick_r5: assert property (@(posedge clk) disable iff (rst)
        (!tune_load && !cmp_tick && timeout_val >= MinT) |=> $stable(cnt_q));

    // R5: the fast gain is applied while counting in timed mode
    p_fast_gain_r5: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != '0 && timeout_val >= MinT) |-> (cp_gain == gain_fast));

    // R6: on the last remaining tick the pin is low but the gain is still fast
    p_pin_early_release_r6: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == TMO_W'(1) && timeout_val >= MinT) |-> (!aux_pin_val && cp_gain == gain_fast));

    // R7: no rate reduction outside the fast state
    p_rate_idle_r7: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '0) |-> (rate_factor == RATE_W'(1)));

    // R2: timeout value zero releases the pin
    p_gp_hiz_r2: assert property (@(posedge clk) disable iff (rst)
        (timeout_val == '0) |-> !aux_pin_oe);

    // R11: a low timeout value clears the fast state
    p_abandon_r11: assert property (@(posedge clk) disable iff (rst)
        (timeout_val < MinT) |=> (cnt_q == '0));
endmodule

bind fastlock_timeout_ctrl ftc_checker #(
    .TMO_W(TMO_W), .GAIN_W(GAIN_W), .RATE_W(RATE_W), .MIN_TMO(MIN_TMO)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tune_load   (tune_load),
    .cmp_tick    (cmp_tick),
    .timeout_val (timeout_val),
    .gain_fast   (gain_fast),
    .cp_gain     (cp_gain),
    .rate_factor (rate_factor),
    .aux_pin_oe  (aux_pin_oe),
    .aux_pin_val (aux_pin_val),
    .cnt_q       (cnt_q)
);

// File: tb/fastlock_timeout_ctrl_test.sv
module fastlock_timeout_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tune_load = 1'b0;
    logic        cmp_tick = 1'b0;
    logic [13:0] timeout_val = 14'd8;
    logic [1:0]  gain_steady = 2'd0;
    logic [1:0]  gain_fast = 2'd3;
    logic [1:0]  csr_code = 2'd0;
    logic [1:0]  cp_gain;
    logic [3:0]  rate_factor;
    logic        aux_pin_oe;
    logic        aux_pin_val;

    int checks = 0;
    int errors = 0;
    int exp_cnt = 0;
    bit done = 1'b0;

    fastlock_timeout_ctrl uut (
        .clk(clk), .rst(rst), .tune_load(tune_load), .cmp_tick(cmp_tick),
        .timeout_val(timeout_val), .gain_steady(gain_steady), .gain_fast(gain_fast),
        .csr_code(csr_code), .cp_gain(cp_gain), .rate_factor(rate_factor),
        .aux_pin_oe(aux_pin_oe), .aux_pin_val(aux_pin_val)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic bit timed(); return timeout_val >= 14'd4; endfunction

    function automatic int exp_gain();
        if (timed()) return (exp_cnt != 0) ? int'(gain_fast) : int'(gain_steady);
        return (timeout_val == 14'd3) ? int'(gain_fast) : int'(gain_steady);
    endfunction

    function automatic int exp_rate();
        return (timed() && exp_cnt != 0) ? (1 << csr_code) : 1;
    endfunction

    function automatic int exp_oe();
        return timed() ? 1 : int'(timeout_val != 14'd0);
    endfunction

    function automatic int exp_val();
        return timed() ? int'(exp_cnt >= 2) : int'(timeout_val >= 14'd2);
    endfunction

    task automatic check_all();
        string tg, tp;
        if (timed()) begin
            tg = (exp_cnt != 0) ? "R5 gain" : "R10 gain";
            tp = (exp_cnt >= 2) ? "R4 pin" : "R6 pin";
        end else begin
            tg = (timeout_val == 14'd3) ? "R3 gain" : "R2 gain";
            tp = (timeout_val == 14'd3) ? "R3 pin" : "R2 pin";
        end
        chk(tg, int'(cp_gain), exp_gain());
        chk("R7 rate", int'(rate_factor), exp_rate());
        chk({tp, " oe"}, int'(aux_pin_oe), exp_oe());
        chk({tp, " val"}, int'(aux_pin_val), exp_val());
    endtask

    // One cycle: drive at negedge, update model at posedge, check at next negedge
    task automatic cyc(input bit ld, input bit tk);
        tune_load = ld;
        cmp_tick  = tk;
        @(posedge clk);
        if (!timed())             exp_cnt = 0;
        else if (ld)              exp_cnt = int'(timeout_val);
        else if (tk && exp_cnt != 0) exp_cnt--;
        @(negedge clk);
        tune_load = 1'b0;
        cmp_tick  = 1'b0;
        check_all();
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd20250611);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        exp_cnt = 0;
        @(negedge clk);
        // R1: reset state in timed mode
        chk("R1 gain", int'(cp_gain), 0);
        chk("R1 rate", int'(rate_factor), 1);
        chk("R1 oe", int'(aux_pin_oe), 1);
        chk("R1 val", int'(aux_pin_val), 0);

        // R2 / R3: general-purpose codes, loads ignored (R9)
        gain_steady = 2'd1; gain_fast = 2'd2; csr_code = 2'd3;
        for (int c = 0; c < 4; c++) begin
            timeout_val = 14'(c);
            cyc(1'b1, 1'b1);   // R9: load with low timeout has no effect
            cyc(1'b0, 1'b1);
        end

        // R4, R5, R6, R7: timeout 5 with gapped ticks
        timeout_val = 14'd5; csr_code = 2'd2;
        cyc(1'b0, 1'b0);
        cyc(1'b1, 1'b0);
        for (int i = 0; i < 14; i++) cyc(1'b0, (i % 3) == 0);

        // R8: reload mid-way, and load wins over a simultaneous tick
        cyc(1'b1, 1'b0);
        cyc(1'b0, 1'b1);
        cyc(1'b0, 1'b1);
        cyc(1'b1, 1'b1);
        chk("R8 reload", int'(cp_gain), int'(gain_fast));
        for (int i = 0; i < 6; i++) cyc(1'b0, 1'b1);

        // R11: drop timeout during fast state, then restore it
        cyc(1'b1, 1'b0);
        cyc(1'b0, 1'b1);
        timeout_val = 14'd1;
        cyc(1'b0, 1'b0);
        timeout_val = 14'd5;
        cyc(1'b0, 1'b0);
        chk("R11 not resumed", int'(cp_gain), int'(gain_steady));

        // R5: full-range timeout
        timeout_val = 14'd16383; csr_code = 2'd1;
        cyc(1'b1, 1'b0);
        for (int i = 0; i < 16384; i++) cyc(1'b0, 1'b1);

        // Random mix
        for (int i = 0; i < 6000; i++) begin
            if (($urandom % 40) == 0)
                timeout_val = (($urandom % 4) == 0) ? 14'($urandom % 4) : 14'(4 + ($urandom % 9));
            if (($urandom % 25) == 0) begin
                gain_steady = 2'($urandom); gain_fast = 2'($urandom); csr_code = 2'($urandom);
            end
            cyc(($urandom % 20) == 0, ($urandom % 2) == 0);
        end

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule